// File: doc/BRIEF.md
# Banked Event/Level Interrupt Controller

This block gathers up to 64 interrupt lines into two banks of 32 and raises one request line toward a processor. Each line passes through a two-flop synchronizer. Edge-type lines latch a sticky event bit on a rising edge. Software clears that bit by writing a one to the matching bit of the bank's acknowledge register. Level-type lines never latch. Their pending state is the live, synchronized input, which software reads through the bank's level register. A fixed per-bank mask chooses which lines are level-type. The result is that enabling a level line that is already high raises the request from its live state and does not create a stale event.

Software reaches the block over a plain 32-bit register bus inside a 64-byte window. Byte enables select little-endian byte lanes, so lane i covers bits 8i+7:8i. Every access completes in the cycle it is presented, and there is no back-pressure. A read returns its data, marked by a one-cycle valid pulse, in the cycle after the access. The read data holds its value until the next read.

Top module: `evlvl_intc`

## Requirements
- R1: Each bank's registers sit at word offsets +0x0 (event), +0x4 (enable), +0x8 (acknowledge) and +0xC (level). Sources 0–31 form bank 0 at base 0x20, and sources 32–63 form bank 1 at base 0x10. Source n uses bank n>>5, bit n&31.
- R2: For an edge-type source, a rising edge on its input sets its event bit three clock edges after the input changes (two synchronizer flops plus the event flop). The enable bit has no effect on this. Once set, the event bit stays set until it is acknowledged.
- R3: Writing the acknowledge register clears every event bit that is written as 1 in an enabled byte lane. Bits written as 0 keep their value.
- R4: If a rising edge and an acknowledge of the same bit fall on the same clock edge, the event bit ends up set.
- R5: Bank 0 bits 20–28 (mask 0x1FF00000) are level-type, and bank 1 has none. A level-type source never sets its event bit. Enabling it while its input is already high leaves its event bit at 0.
- R6: The level register reads the synchronized live state of all 32 inputs of the bank, whatever their enable bits.
- R7: The enable register reads back the value last written, updated per byte lane as the byte enables select.
- R8: `irq` is high exactly when some bank has a bit set in (event | (live & level mask)) & enable.
- R9: Reset clears all enable bits, all event bits, the read data and the read-valid pulse, so `irq` is low.
- R10: These accesses read 0 and ignore writes: an address with bits [5:4] equal to 00 or 11, an address that is not word-aligned, and a read of the acknowledge register.
- R11: A read returns its data with `bus_rvalid` high in the following cycle. `bus_rdata` keeps its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address in the 64-byte window |
| bus_be | input | 4 | Write byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| src_in | input | 64 | Interrupt source lines, asynchronous |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions take it for granted that software writes the acknowledge register only to clear events. An event bit is therefore expected never to drop in a cycle without such a write. They also assume that the enable register changes only on a write to its own address. Stimulus keeps to this by driving bus strobes and source lines at the falling clock edge, one access at a time. Source lines are held long enough for the synchronizer to see them. The same-edge race of R4 is set up by counting synchronizer stages, so that the acknowledge lands on exactly the edge where the event flop captures the rising edge.

// File: rtl/evlvl_intc_pkg.sv
package evlvl_intc_pkg;
  // register kind selected by address bits [3:2]
  typedef enum logic [1:0] {
    REG_EVT = 2'd0,
    REG_ENA = 2'd1,
    REG_ACK = 2'd2,
    REG_LVL = 2'd3
  } reg_kind_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      q_sync   <= '0;
    end else begin
      stage1_q <= d_async;
      q_sync   <= stage1_q;
    end
  end
endmodule

// File: rtl/intc_regdec.sv
module intc_regdec
  import evlvl_intc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned NB       = 2,
  parameter int unsigned TOP_SLOT = 2,
  localparam int unsigned BIDX_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [BIDX_W-1:0] bank_idx,
  output reg_kind_e         kind
);
  localparam int unsigned SLOT_W = ADDR_W - 4;
  localparam int LOW_SLOT = int'(TOP_SLOT) - int'(NB) + 1;

  logic [SLOT_W-1:0] slot;
  int                slot_i;
  int                bank_i;

  always_comb begin
    slot     = addr[ADDR_W-1:4];
    slot_i   = int'(slot);
    bank_i   = int'(TOP_SLOT) - slot_i;
    hit      = (addr[1:0] == 2'b00) && (slot_i <= int'(TOP_SLOT)) && (slot_i >= LOW_SLOT);
    bank_idx = BIDX_W'(bank_i);
    kind     = reg_kind_e'(addr[3:2]);
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import evlvl_intc_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] LVL_MASK = '0,
  localparam int unsigned BE_W    = W / LANE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    line_s,
  input  logic            wr_ena,
  input  logic            wr_ack,
  input  logic [W-1:0]    wdata,
  input  logic [BE_W-1:0] be,
  output logic [W-1:0]    evt_q,
  output logic [W-1:0]    ena_q,
  output logic            pend
);
  logic [W-1:0] lane_mask;
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] clr;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{be[g]}};
  end

  // level-type lines never produce an edge event
  assign rise = line_s & ~prev_q & ~LVL_MASK;
  assign clr  = wr_ack ? (wdata & lane_mask) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
      ena_q  <= '0;
    end else begin
      prev_q <= line_s;
      // a new edge wins over a simultaneous acknowledge
      evt_q  <= (evt_q & ~clr) | rise;
      if (wr_ena) ena_q <= (ena_q & ~lane_mask) | (wdata & lane_mask);
    end
  end

  assign pend = |((evt_q | (line_s & LVL_MASK)) & ena_q);
endmodule

// File: rtl/evlvl_intc.sv
module evlvl_intc
  import evlvl_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 64,
  parameter int unsigned BW          = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned TOP_SLOT    = 2,
  parameter logic [31:0] LVL_MASK_LO = 32'h1FF0_0000,
  parameter logic [31:0] LVL_MASK_HI = 32'h0000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BW/8-1:0]    bus_be,
  input  logic [BW-1:0]      bus_wdata,
  output logic               bus_rvalid,
  output logic [BW-1:0]      bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq
);
  localparam int unsigned NB     = NUM_SRC / BW;
  localparam int unsigned BIDX_W = (NB > 1) ? $clog2(NB) : 1;

  logic [NUM_SRC-1:0]       src_s;
  logic                     hit;
  logic [BIDX_W-1:0]        bank_idx;
  reg_kind_e                kind;
  logic [NB-1:0][BW-1:0]    ev_all;
  logic [NB-1:0][BW-1:0]    en_all;
  logic [NB-1:0][BW-1:0]    lv_all;
  logic [NB-1:0]            pend_all;
  logic [BW-1:0]            rd_mux;
  logic                     wr_acc;
  logic                     rd_acc;

  assign wr_acc = bus_sel & bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;

  intc_sync #(.W(NUM_SRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (src_in),
    .q_sync  (src_s)
  );

  intc_regdec #(.ADDR_W(ADDR_W), .NB(NB), .TOP_SLOT(TOP_SLOT)) u_dec (
    .addr     (bus_addr),
    .hit      (hit),
    .bank_idx (bank_idx),
    .kind     (kind)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel_b;
    assign sel_b      = wr_acc & hit & (bank_idx == BIDX_W'(b));
    assign lv_all[b]  = src_s[b*BW +: BW];

    intc_bank #(
      .W        (BW),
      .LVL_MASK ((b == 0) ? LVL_MASK_LO[BW-1:0] : LVL_MASK_HI[BW-1:0])
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_s (src_s[b*BW +: BW]),
      .wr_ena (sel_b & (kind == REG_ENA)),
      .wr_ack (sel_b & (kind == REG_ACK)),
      .wdata  (bus_wdata),
      .be     (bus_be),
      .evt_q  (ev_all[b]),
      .ena_q  (en_all[b]),
      .pend   (pend_all[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (kind)
        REG_EVT: rd_mux = ev_all[bank_idx];
        REG_ENA: rd_mux = en_all[bank_idx];
        REG_LVL: rd_mux = lv_all[bank_idx];
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_acc;
      if (rd_acc) bus_rdata <= rd_mux;
    end
  end

  assign irq = |pend_all;
endmodule

// File: rtl/evlvl_intc_chk.sv
module evlvl_intc_chk #(
  parameter int unsigned NB          = 2,
  parameter int unsigned BW          = 32,
  parameter logic [31:0] LVL_MASK_LO = 32'h1FF0_0000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [5:0]            bus_addr,
  input logic                  bus_rvalid,
  input logic [BW-1:0]         bus_rdata,
  input logic                  irq,
  input logic [NB-1:0][BW-1:0] ev_all,
  input logic [NB-1:0][BW-1:0] en_all
);
  logic rd_acc;
  logic unmapped;
  assign rd_acc   = bus_sel && !bus_wr;
  assign unmapped = (bus_addr[5:4] == 2'b00) || (bus_addr[5:4] == 2'b11);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && unmapped) |=> (bus_rvalid && bus_rdata == '0));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(bus_rdata));

  p_event_sticky_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == 6'h28)
      |=> ((ev_all[0] & $past(ev_all[0])) == $past(ev_all[0])));

  p_event_sticky_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == 6'h18)
      |=> ((ev_all[1] & $past(ev_all[1])) == $past(ev_all[1])));

  p_level_no_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_all[0] & LVL_MASK_LO[BW-1:0]) == '0);

  p_enable_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == 6'h24) |=> $stable(en_all[0]));

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |-> !irq);
endmodule

bind evlvl_intc evlvl_intc_chk #(
  .NB(NB), .BW(BW), .LVL_MASK_LO(LVL_MASK_LO)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rvalid (bus_rvalid),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .ev_all     (ev_all),
  .en_all     (en_all)
);

// File: tb/evlvl_intc_bench.sv
`timescale 1ns/1ps
module evlvl_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  evlvl_intc u_evlvl_intc (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .src_in(src_in), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every read response is compared with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 actual=unexpected-response expected=none");
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d, logic [3:0] be);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9 irq", {31'b0, irq}, 32'h0);
    rd(6'h20, 32'h0, "R9 event lo");
    rd(6'h24, 32'h0, "R9 enable lo");
    rd(6'h10, 32'h0, "R9 event hi");
    // R7: enable readback with byte lanes
    wr(6'h24, 32'hA5A5_0F0F, 4'hF);
    rd(6'h24, 32'hA5A5_0F0F, "R7 full write");
    wr(6'h24, 32'hFFFF_FFFF, 4'b0010);
    rd(6'h24, 32'hA5A5_FF0F, "R7 lane 1 only");
    wr(6'h24, 32'h0, 4'hF);
    // R2 / R1: edges latch regardless of enable; bank placement
    src_in[3] = 1'b1;
    src_in[40] = 1'b1;
    settle();
    rd(6'h20, 32'h0000_0008, "R2 edge source 3 latched");
    rd(6'h10, 32'h0000_0100, "R1 source 40 in bank at 0x10 bit 8");
    check("R8 irq low with nothing enabled", {31'b0, irq}, 32'h0);
    // R8: enable the pending source
    wr(6'h14, 32'h0000_0100, 4'hF);
    check("R8 irq high", {31'b0, irq}, 32'h1);
    // R3: zero write keeps, one write clears
    wr(6'h18, 32'h0, 4'hF);
    rd(6'h10, 32'h0000_0100, "R3 zero ack keeps");
    check("R3 irq kept", {31'b0, irq}, 32'h1);
    wr(6'h18, 32'h0000_0100, 4'hF);
    rd(6'h10, 32'h0, "R3 one ack clears");
    check("R3 irq dropped", {31'b0, irq}, 32'h0);
    // R5 / R6: level source enabled while already high
    src_in[22] = 1'b1;
    settle();
    wr(6'h24, 32'h0040_0000, 4'hF);
    check("R5 irq from live level", {31'b0, irq}, 32'h1);
    rd(6'h20, 32'h0000_0008, "R5 no event for level source");
    rd(6'h2C, 32'h0040_0008, "R6 level reg lo");
    rd(6'h1C, 32'h0000_0100, "R6 level reg hi unenabled");
    src_in[22] = 1'b0;
    settle();
    check("R5 irq follows level low", {31'b0, irq}, 32'h0);
    rd(6'h20, 32'h0000_0008, "R5 event still clear");
    // R4: edge and acknowledge on the same clock edge
    src_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(6'h28, 32'h0000_0020, 4'hF);
    rd(6'h20, 32'h0000_0028, "R4 edge wins over ack");
    wr(6'h28, 32'h0000_0008, 4'hF);
    rd(6'h20, 32'h0000_0020, "R3 ack bit 3 only");
    // R10: unmapped, misaligned, ack readback
    wr(6'h00, 32'hFFFF_FFFF, 4'hF);
    wr(6'h34, 32'hFFFF_FFFF, 4'hF);
    wr(6'h25, 32'h0, 4'hF);
    rd(6'h00, 32'h0, "R10 unmapped low");
    rd(6'h3C, 32'h0, "R10 unmapped high");
    rd(6'h28, 32'h0, "R10 ack reads zero");
    rd(6'h26, 32'h0, "R10 misaligned read");
    rd(6'h24, 32'h0040_0000, "R10 enable untouched");
    rd(6'h14, 32'h0000_0100, "R10 hi enable untouched");
    // R11: hold between reads, no stray response
    repeat (3) @(negedge clk);
    check("R11 rdata held", bus_rdata, 32'h0000_0100);
    check("R11 rvalid idle", {31'b0, bus_rvalid}, 32'h0);
    // R9: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 irq after reset", {31'b0, irq}, 32'h0);
    rd(6'h24, 32'h0, "R9 enable cleared");
    rd(6'h20, 32'h0, "R9 event cleared");
    repeat (3) @(negedge clk);
    check("R11 all responses seen", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule